// File: doc/BRIEF.md
# Windowed Oscillator Frequency Meter

The block measures the frequency of one oscillator chosen from a small set. A reference clock, nominally 26 MHz, times a gate window of a fixed number of reference cycles. During that window the selected oscillator, optionally slowed by a prescaler, advances a counter that runs in the oscillator's own clock domain. The window is 1024 reference cycles, so at 26 MHz the reading converts to MHz as count × 26 / 1024. At that reference rate one measurement takes about 40 µs.

Control is a set of register-style fields held on plain ports: a meter enable level, a one-cycle request that sets the run bit, a 6-bit source code, an 8-bit prescale value and a 2-bit mode. Software sets run with the meter enabled and polls until hardware drops run. The 16-bit result then holds the new count. The gate level crosses into the measured domain through a two-flop synchronizer, and its rising edge serves as the start event there. The finished count comes back under a toggle handshake, so the reference side only ever captures a settled value. Dropping the enable cancels a measurement in flight.

Top module: `osc_freq_meter`

## Requirements
- R1: A run request is accepted only while `meter_en` is high and no measurement is in progress; a request with `meter_en` low leaves `run_busy` at 0 and `count_value` unchanged.
- R2: `run_busy` rises the cycle after an accepted request and falls by itself once `count_value` holds the new result; the gate is never open while `run_busy` is low.
- R3: The gate window lasts exactly WINDOW (1024) `ref_clk` cycles, so the count equals f_osc × WINDOW / f_ref within a few counts, and a measurement keeps `run_busy` high for WINDOW to WINDOW+16 reference cycles.
- R4: Source code 0x25 selects `osc_clk[0]` and code 0x24 selects `osc_clk[1]`; in general code 0x25−i selects `osc_clk[i]`.
- R5: With prescale value P, the count advances once per P+1 edges of the selected oscillator; P = 0 counts every edge.
- R6: If mode is not 0, or the source code selects no oscillator, the measurement still lasts the full window and ends with `count_value` = 0.
- R7: The count saturates at 0xFFFF and does not wrap when the oscillator is too fast for the window.
- R8: Dropping `meter_en` during a measurement clears `run_busy` on the next clock edge and leaves `count_value` at its previous value.
- R9: After reset, `run_busy` is 0 and `count_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that times the gate window |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| osc_clk | input | NUM_OSC | Oscillator clocks that can be measured |
| meter_en | input | 1 | Meter enable level; low cancels a measurement |
| run_req | input | 1 | One-cycle pulse that sets the run bit |
| src_sel | input | SEL_W (6) | Source code, 0x25−i selects osc_clk[i] |
| prescale | input | PRE_W (8) | Oscillator divide value minus one |
| mode | input | MODE_W (2) | Must be 0 for the source code to apply |
| run_busy | output | 1 | Run bit; hardware clears it when done |
| count_value | output | CNT_W (16) | Last completed count |

## Verification
The hardest case is a cancel that lands while the measured domain is still counting or handing back its count. The stale handshake toggle then arrives after the reference side has already gone idle, and it must not corrupt the stored result or the next measurement. The stimulus first runs a normal measurement so that a known count is stored. It then starts another, drops the enable a few hundred cycles into the window, checks that the run bit fell and that the count is unchanged, and finally runs a fresh measurement on the other oscillator, whose result must be correct. Saturation is reached by shortening one oscillator's period in the bench until more than 65535 edges fall inside the window.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;

  // Highest source code; code (SRC_TOP - i) selects oscillator i.
  localparam int SRC_TOP = 'h25;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_WAIT = 2'd2
  } fm_state_e;

endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/fm_count_core.sv
`timescale 1ns/1ps
module fm_count_core #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             mclk,
  input  logic             mrst,
  input  logic             gate_a,
  input  logic [PRE_W-1:0] prescale,
  output logic [CNT_W-1:0] hold_o,
  output logic             done_tgl_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gate_s;
  logic             gate_d;
  logic             gate_rise;
  logic             gate_fall;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre_cnt;

  fm_sync #(.W(1)) u_gate_sync (
    .clk (mclk),
    .rst (mrst),
    .d   (gate_a),
    .q   (gate_s)
  );

  assign gate_rise = gate_s & ~gate_d;
  assign gate_fall = ~gate_s & gate_d;

  always_ff @(posedge mclk) begin
    if (mrst) begin
      gate_d     <= 1'b0;
      cnt        <= '0;
      pre_cnt    <= '0;
      hold_o     <= '0;
      done_tgl_o <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (gate_rise) begin
        cnt     <= '0;
        pre_cnt <= '0;
      end else if (gate_s) begin
        if (pre_cnt == prescale) begin
          pre_cnt <= '0;
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
      if (gate_fall) begin
        hold_o     <= cnt;
        done_tgl_o <= ~done_tgl_o;
      end
    end
  end

  AST_SAT_HOLD: assert property (@(posedge mclk) disable iff (mrst)
    ($past(cnt) == CNT_MAX && !$past(gate_rise)) |-> (cnt == CNT_MAX)); // R7

endmodule

// File: rtl/fm_ctrl.sv
`timescale 1ns/1ps
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int NUM_OSC = 2,
  parameter int WINDOW  = 1024,
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 6,
  parameter int MODE_W  = 2,
  parameter int IDX_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              run_req,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [MODE_W-1:0] mode,
  input  logic              done_tgl_a,
  input  logic [CNT_W-1:0]  hold_in,
  output logic              gate_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              run_o,
  output logic [CNT_W-1:0]  result_o
);

  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
  localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(SRC_TOP);

  fm_state_e        st;
  logic [WIN_W-1:0] tmr;
  logic             live;
  logic             done_s;
  logic             done_d;
  logic             done_edge;
  logic [SEL_W-1:0] offs;
  logic             src_ok;

  fm_sync #(.W(1)) u_done_sync (
    .clk (clk),
    .rst (rst),
    .d   (done_tgl_a),
    .q   (done_s)
  );

  assign done_edge = done_s ^ done_d;
  assign offs      = TOP_CODE - src_sel;
  assign src_ok    = (mode == '0) && (src_sel <= TOP_CODE) &&
                     (offs < SEL_W'(NUM_OSC));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tmr      <= '0;
      live     <= 1'b0;
      done_d   <= 1'b0;
      gate_o   <= 1'b0;
      pre_o    <= '0;
      idx_o    <= '0;
      run_o    <= 1'b0;
      result_o <= '0;
    end else begin
      done_d <= done_s;
      case (st)
        ST_IDLE: begin
          if (enable && run_req) begin
            run_o  <= 1'b1;
            gate_o <= 1'b1;
            tmr    <= '0;
            live   <= src_ok;
            pre_o  <= prescale;
            if (src_ok) idx_o <= IDX_W'(offs);
            st     <= ST_GATE;
          end
        end
        ST_GATE: begin
          if (!enable) begin
            gate_o <= 1'b0;
            run_o  <= 1'b0;
            st     <= ST_IDLE;
          end else if (tmr == WIN_LAST) begin
            gate_o <= 1'b0;
            if (live) begin
              st <= ST_WAIT;
            end else begin
              run_o    <= 1'b0;
              result_o <= '0;
              st       <= ST_IDLE;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAIT: begin
          if (!enable) begin
            run_o <= 1'b0;
            st    <= ST_IDLE;
          end else if (done_edge) begin
            result_o <= hold_in;
            run_o    <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Checker state: number of consecutive cycles the gate has been open.
  logic [WIN_W:0] chk_len;
  always_ff @(posedge clk) begin
    if (rst) chk_len <= '0;
    else     chk_len <= gate_o ? chk_len + 1'b1 : '0;
  end

  AST_GATE_MAX: assert property (@(posedge clk) disable iff (rst)
    chk_len <= (WIN_W+1)'(WINDOW)); // R3
  AST_GATE_FULL: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_o) && run_o) |-> (chk_len == (WIN_W+1)'(WINDOW))); // R3
  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(run_o) |-> $past(enable)); // R1
  AST_NO_GATE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> !gate_o); // R2
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !run_o); // R8
  AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (run_o && !enable) |=> $stable(result_o)); // R8

endmodule

// File: rtl/osc_freq_meter.sv
`timescale 1ns/1ps
module osc_freq_meter #(
  parameter int NUM_OSC = 2,
  parameter int WINDOW  = 1024,
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 6,
  parameter int MODE_W  = 2
) (
  input  logic               ref_clk,
  input  logic               ref_rst,
  input  logic [NUM_OSC-1:0] osc_clk,
  input  logic               meter_en,
  input  logic               run_req,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [PRE_W-1:0]   prescale,
  input  logic [MODE_W-1:0]  mode,
  output logic               run_busy,
  output logic [CNT_W-1:0]   count_value
);

  localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

  logic             gate;
  logic [PRE_W-1:0] pre_q;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] hold;
  logic             done_tgl;
  logic             mclk;
  logic             mrst;

  // Selected oscillator; the index only changes when a measurement starts.
  assign mclk = osc_clk[idx];

  fm_sync #(.W(1)) u_mrst_sync (
    .clk (mclk),
    .rst (1'b0),
    .d   (ref_rst),
    .q   (mrst)
  );

  fm_ctrl #(
    .NUM_OSC (NUM_OSC),
    .WINDOW  (WINDOW),
    .CNT_W   (CNT_W),
    .PRE_W   (PRE_W),
    .SEL_W   (SEL_W),
    .MODE_W  (MODE_W),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk        (ref_clk),
    .rst        (ref_rst),
    .enable     (meter_en),
    .run_req    (run_req),
    .src_sel    (src_sel),
    .prescale   (prescale),
    .mode       (mode),
    .done_tgl_a (done_tgl),
    .hold_in    (hold),
    .gate_o     (gate),
    .pre_o      (pre_q),
    .idx_o      (idx),
    .run_o      (run_busy),
    .result_o   (count_value)
  );

  fm_count_core #(
    .CNT_W (CNT_W),
    .PRE_W (PRE_W)
  ) u_core (
    .mclk       (mclk),
    .mrst       (mrst),
    .gate_a     (gate),
    .prescale   (pre_q),
    .hold_o     (hold),
    .done_tgl_o (done_tgl)
  );

endmodule

// File: tb/test_osc_freq_meter.sv
`timescale 1ns/1ps
module test_osc_freq_meter;

  localparam real CLK_PERIOD = 10.0;
  localparam int  WINDOW     = 1024;

  typedef struct {
    int    lo;
    int    hi;
    bit    keep;
    string tag;
  } exp_t;

  logic       ref_clk = 1'b0;
  logic       ref_rst = 1'b1;
  logic [1:0] osc_clk = 2'b00;
  logic       meter_en = 1'b0;
  logic       run_req = 1'b0;
  logic [5:0] src_sel = '0;
  logic [7:0] prescale = '0;
  logic [1:0] mode = '0;
  logic       run_busy;
  logic [15:0] count_value;

  real a_half = 2.0;
  real b_half = 3.5;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int last_count = 0;
  int run_len  = 0;
  bit prev_run = 1'b0;
  exp_t sb[$];

  osc_freq_meter i_osc_freq_meter (
    .ref_clk     (ref_clk),
    .ref_rst     (ref_rst),
    .osc_clk     (osc_clk),
    .meter_en    (meter_en),
    .run_req     (run_req),
    .src_sel     (src_sel),
    .prescale    (prescale),
    .mode        (mode),
    .run_busy    (run_busy),
    .count_value (count_value)
  );

  always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;
  always #(a_half) osc_clk[0] = ~osc_clk[0];
  always #(b_half) osc_clk[1] = ~osc_clk[1];

  task automatic check(input bit ok, input string req, input int act, input int exp_lo,
                       input int exp_hi);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  // Monitor: pops the scoreboard whenever the run bit falls.
  always @(negedge ref_clk) begin
    if (run_busy) run_len++;
    if (prev_run && !run_busy) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected completion", int'(count_value), 0, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.keep) begin
          check(int'(count_value) == last_count, {e.tag, " R8 count kept"},
                int'(count_value), last_count, last_count);
        end else begin
          check(int'(count_value) >= e.lo && int'(count_value) <= e.hi,
                {e.tag, " count"}, int'(count_value), e.lo, e.hi);
          check(run_len >= WINDOW && run_len <= WINDOW + 16,
                {e.tag, " R3 busy length"}, run_len, WINDOW, WINDOW + 16);
        end
      end
      last_count = int'(count_value);
    end
    if (!run_busy) run_len = 0;
    prev_run = run_busy;
  end

  task automatic start(input logic [5:0] sel, input logic [7:0] pre, input logic [1:0] md);
    @(negedge ref_clk);
    src_sel  = sel;
    prescale = pre;
    mode     = md;
    run_req  = 1'b1;
    @(negedge ref_clk);
    run_req  = 1'b0;
  endtask

  task automatic measure(input logic [5:0] sel, input logic [7:0] pre, input logic [1:0] md,
                         input int lo, input int hi, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.keep = 1'b0; e.tag = tag;
    sb.push_back(e);
    start(sel, pre, md);
    while (run_busy) @(negedge ref_clk);
    repeat (4) @(negedge ref_clk);
  endtask

  // Watchdog
  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge ref_clk);
    ref_rst = 1'b0;
    @(negedge ref_clk);
    // R9: reset state
    check(run_busy == 1'b0, "R9 run after reset", int'(run_busy), 0, 0);
    check(count_value == 16'd0, "R9 count after reset", int'(count_value), 0, 0);

    meter_en = 1'b1;
    // R3/R4: osc 0 (code 0x25) at 4 ns vs 10 ns reference -> 2560 edges
    measure(6'h25, 8'd0, 2'd0, 2555, 2563, "R4 osc0");
    // R4: osc 1 (code 0x24) at 7 ns -> 1463 edges
    measure(6'h24, 8'd0, 2'd0, 1458, 1466, "R4 osc1");
    // R5: prescale 3 on osc 0 -> 640
    measure(6'h25, 8'd3, 2'd0, 636, 643, "R5 prescale3");
    // R6: nonzero mode gives zero
    measure(6'h25, 8'd0, 2'd1, 0, 0, "R6 mode1");
    // R6: unknown source code gives zero
    measure(6'h10, 8'd0, 2'd0, 0, 0, "R6 badcode");
    // R7: 0.1 ns oscillator -> 102400 edges, saturates
    a_half = 0.05;
    measure(6'h25, 8'd0, 2'd0, 65535, 65535, "R7 saturate");
    a_half = 2.0;
    measure(6'h25, 8'd0, 2'd0, 2555, 2563, "R3 osc0 again");

    // R8: cancel in the middle of the window
    begin
      exp_t e;
      e.lo = 0; e.hi = 0; e.keep = 1'b1; e.tag = "abort";
      sb.push_back(e);
    end
    start(6'h24, 8'd0, 2'd0);
    repeat (300) @(negedge ref_clk);
    meter_en = 1'b0;
    @(negedge ref_clk);
    check(run_busy == 1'b0, "R8 run cleared on cancel", int'(run_busy), 0, 0);
    repeat (20) @(negedge ref_clk);
    meter_en = 1'b1;
    repeat (5) @(negedge ref_clk);
    measure(6'h24, 8'd0, 2'd0, 1458, 1466, "R8 after cancel osc1");

    // R1: request with enable low is ignored
    meter_en = 1'b0;
    start(6'h25, 8'd0, 2'd0);
    repeat (5) @(negedge ref_clk);
    check(run_busy == 1'b0, "R1 run with enable low", int'(run_busy), 0, 0);
    check(int'(count_value) == last_count, "R1 count unchanged", int'(count_value),
          last_count, last_count);

    repeat (10) @(negedge ref_clk);
    check(sb.size() == 0, "R2 all measurements completed", sb.size(), 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule